// File: doc/BRIEF.md
# Streaming Min/Max Extractor and Priority Queue

This block finds the largest and the smallest key held in a P×P matrix of slots, using only the first two phases of a matrix sort. Phase one sorts every column so that the largest key of each column comes first. Phase two sorts the top row so that the largest key comes first, and sorts the bottom row in the opposite direction. After phase two, the global maximum is in the top-left slot and the global minimum is in the bottom-left slot (for an odd P it is at the bottom right). Both phases are built from one P-input compare-exchange network per line. The phase-one result is registered.

A 2-bit mode input selects one of two uses. In stream mode the block keeps the running maximum and minimum in two resident slots. The other N−2 slots take new records; when they are full, or when the final record of a stream arrives, a two-cycle pass folds them into the two extremes. In queue mode the slots hold task keys, such as relative deadlines. A new task is accepted while there is room. Once the queue is full, a new task replaces the current maximum only if its key is strictly smaller than that maximum. A pop removes the minimum-key task. Each pass refreshes both extremes, and the two are presented on the outputs in the same cycle.

Top module: `mmx_extract`

## Requirements
- R1: `mode_i` is decoded as follows: 2'b01 selects stream, 2'b10 selects queue, and 2'b00 (full sort, not provided by this block) and 2'b11 are inert. In an inert mode, `in_ready_o`, `out_valid_o`, `reject_o` and `pop_err_o` stay low, and stimulus on the inputs leaves no trace in the contents.
- R2: In stream mode, `out_valid_o` rises within three cycles after the record flagged `in_last_i` is accepted. At that point `max_o` and `min_o` equal the largest and smallest keys of the whole stream. The result is held until the next record is accepted.
- R3: In stream mode, after every N−2 accepted records of a stream, `in_ready_o` drops for exactly two cycles while the pass runs. It is never low for more than two consecutive cycles.
- R4: In stream mode, a final batch shorter than N−2 records, including a stream of one record, yields the correct extremes. Unused slots never supply either extreme.
- R5: In queue mode, while fewer than N tasks are held, every offered key is accepted. After the pass, `max_o` and `min_o` are the largest and smallest keys held.
- R6: In queue mode with all N slots in use, a key strictly below `max_o` replaces the maximum entry. A key equal to or above `max_o` is rejected: `reject_o` is high in the handshake cycle, and the outputs are unchanged afterwards.
- R7: In queue mode, a pop removes one entry with the minimum key. A pop while the queue is empty raises `pop_err_o` in that cycle and changes nothing.
- R8: `max_o` and `min_o` come from the same pass. Whenever `out_valid_o` is high, `min_o` ≤ `max_o`.
- R9: In queue mode, the outputs change only after an accepted insert or a pop.
- R10: In queue mode, an accepted insert or a pop starts a two-cycle pass. During the pass, `out_valid_o` and `in_ready_o` are low and pops are ignored.
- R11: Any change of `mode_i` empties all slots and discards stream progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Use select (01 stream, 10 queue) |
| in_valid_i | input | 1 | Record offered |
| in_ready_o | output | 1 | Record can be taken this cycle |
| in_key_i | input | W | Record key |
| in_last_i | input | 1 | Final record of a stream |
| pop_i | input | 1 | Remove the minimum-key task |
| max_o | output | W | Largest key |
| min_o | output | W | Smallest key |
| out_valid_o | output | 1 | Extremes are current |
| reject_o | output | 1 | Insert refused by the admission rule |
| pop_err_o | output | 1 | Pop attempted on an empty queue |

## Verification
A wrong slot index carried through the sorter would not show at once. In queue mode it appears at the next pop or replacement, which removes or overwrites the wrong task. The error then surfaces in the extremes reported one pass later, about three cycles after that operation. A padding or direction fault in the row network shows in the first result of a short or skewed batch. For that reason, the streams put their extremes in a last partial batch, and the queue is driven to full before the admission rule is exercised. Stall and busy windows are observed directly on `in_ready_o` and `out_valid_o` in the cycles right after each handshake.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
  typedef enum logic [1:0] {
    MD_SORT   = 2'b00,
    MD_STREAM = 2'b01,
    MD_QUEUE  = 2'b10,
    MD_RSVD   = 2'b11
  } mmx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PH1  = 2'b01,
    ST_PH2  = 2'b10
  } mmx_st_e;
endpackage

// File: rtl/mmx_sortnet.sv
// P-input odd-even transposition network, key in the upper W bits.
module mmx_sortnet #(
  parameter int P  = 4,
  parameter int W  = 16,
  parameter int RW = 20
) (
  input  logic [P-1:0][RW-1:0] rec_i,
  input  logic                 desc_i,
  output logic [P-1:0][RW-1:0] rec_o
);
  always_comb begin
    logic [P-1:0][RW-1:0] v;
    logic [RW-1:0]        t;
    logic                 sw;
    v = rec_i;
    t = '0;
    for (int s = 0; s < P; s++) begin
      for (int i = s % 2; i + 1 < P; i += 2) begin
        sw = desc_i ? (v[i][RW-1 -: W] < v[i+1][RW-1 -: W])
                    : (v[i][RW-1 -: W] > v[i+1][RW-1 -: W]);
        if (sw) begin
          t      = v[i];
          v[i]   = v[i+1];
          v[i+1] = t;
        end
      end
    end
    rec_o = v;
  end
endmodule

// File: rtl/mmx_pass.sv
// Phase 1: registered column sort. Phase 2: top and bottom row sorts (comb).
module mmx_pass #(
  parameter int P  = 4,
  parameter int W  = 16,
  parameter int IW = 4,
  parameter int RW = W + IW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [P*P-1:0][RW-1:0] mat_i,
  output logic [RW-1:0]          max_o,
  output logic [RW-1:0]          min_o
);
  localparam int  N        = P * P;
  localparam bit  LAST_ASC = (P % 2 == 0);

  logic [N-1:0][RW-1:0] col_q;

  for (genvar c = 0; c < P; c++) begin : g_col
    logic [P-1:0][RW-1:0] cin, cout;
    always_comb
      for (int r = 0; r < P; r++) cin[r] = mat_i[r*P+c];
    mmx_sortnet #(.P(P), .W(W), .RW(RW)) u_net (
      .rec_i(cin), .desc_i(1'b1), .rec_o(cout));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < P; r++) col_q[r*P+c] <= '0;
      end else if (load_i) begin
        for (int r = 0; r < P; r++) col_q[r*P+c] <= cout[r];
      end
    end
  end

  logic [P-1:0][RW-1:0] top_in, top_out, bot_in, bot_out;
  always_comb begin
    for (int c = 0; c < P; c++) begin
      top_in[c] = col_q[c];
      bot_in[c] = col_q[(P-1)*P+c];
    end
  end

  mmx_sortnet #(.P(P), .W(W), .RW(RW)) u_top (
    .rec_i(top_in), .desc_i(1'b1), .rec_o(top_out));
  mmx_sortnet #(.P(P), .W(W), .RW(RW)) u_bot (
    .rec_i(bot_in), .desc_i(!LAST_ASC), .rec_o(bot_out));

  assign max_o = top_out[0];
  if (LAST_ASC) begin : g_min_left
    assign min_o = bot_out[0];
  end else begin : g_min_right
    assign min_o = bot_out[P-1];
  end
endmodule

// File: rtl/mmx_extract.sv
module mmx_extract
  import mmx_pkg::*;
#(
  parameter int P = 4,
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_key_i,
  input  logic         in_last_i,
  input  logic         pop_i,
  output logic [W-1:0] max_o,
  output logic [W-1:0] min_o,
  output logic         out_valid_o,
  output logic         reject_o,
  output logic         pop_err_o
);
  localparam int N  = P * P;
  localparam int IW = $clog2(N);
  localparam int RW = W + IW;

  logic [N-1:0][W-1:0]  key_q;
  logic [N-1:0]         vld_q;
  logic [IW-1:0]        fill_q, wr_idx, ref_idx, free_idx;
  mmx_mode_e            mode_q;
  mmx_st_e              st_q;
  logic                 fresh_q, done_q, last_q, res_ok_q;
  logic [RW-1:0]        res_max_q, res_min_q, ext_max, ext_min;
  logic [N-1:0][RW-1:0] mat;
  logic match, idle, stream_en, queue_en, full, in_fire, pop_ok, start, below_max;

  always_comb begin
    ref_idx  = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_q[i])  ref_idx  = IW'(i);
      if (!vld_q[i]) free_idx = IW'(i);
    end
    // empty slots borrow a live entry so they can never win either extreme
    for (int i = 0; i < N; i++)
      mat[i] = vld_q[i] ? {key_q[i], IW'(i)} : {key_q[ref_idx], ref_idx};
  end

  mmx_pass #(.P(P), .W(W), .IW(IW), .RW(RW)) u_pass (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(st_q == ST_PH1),
    .mat_i(mat), .max_o(ext_max), .min_o(ext_min));

  assign match     = (mode_q == mmx_mode_e'(mode_i));
  assign idle      = match && (st_q == ST_IDLE);
  assign stream_en = (mode_q == MD_STREAM);
  assign queue_en  = (mode_q == MD_QUEUE);
  assign full      = &vld_q;
  assign wr_idx    = fill_q + IW'(2);
  assign below_max = in_key_i < res_max_q[RW-1 -: W];

  assign in_ready_o  = idle && (stream_en || (queue_en && !pop_i));
  assign in_fire     = in_valid_i && in_ready_o;
  assign reject_o    = in_fire && queue_en && full && !below_max;
  assign pop_ok      = idle && queue_en && pop_i && (|vld_q);
  assign pop_err_o   = idle && queue_en && pop_i && !(|vld_q);
  assign start       = (in_fire && stream_en && (in_last_i || fill_q == IW'(N - 3)))
                     || (in_fire && queue_en && !reject_o) || pop_ok;
  assign out_valid_o = idle && ((stream_en && done_q) || (queue_en && res_ok_q && (|vld_q)));
  assign max_o       = res_max_q[RW-1 -: W];
  assign min_o       = res_min_q[RW-1 -: W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MD_SORT;
      st_q      <= ST_IDLE;
      key_q     <= '0;
      vld_q     <= '0;
      fill_q    <= '0;
      fresh_q   <= 1'b1;
      done_q    <= 1'b0;
      last_q    <= 1'b0;
      res_ok_q  <= 1'b0;
      res_max_q <= '0;
      res_min_q <= '0;
    end else if (!match) begin
      mode_q   <= mmx_mode_e'(mode_i);
      st_q     <= ST_IDLE;
      vld_q    <= '0;
      fill_q   <= '0;
      fresh_q  <= 1'b1;
      done_q   <= 1'b0;
      last_q   <= 1'b0;
      res_ok_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) st_q <= ST_PH1;
        ST_PH1:  st_q <= ST_PH2;
        default: st_q <= ST_IDLE;
      endcase

      if (in_fire && stream_en) begin
        key_q[wr_idx] <= in_key_i;
        vld_q[wr_idx] <= 1'b1;
        fill_q        <= fill_q + IW'(1);
        done_q        <= 1'b0;
        last_q        <= in_last_i;
        if (fresh_q) begin
          vld_q[0] <= 1'b0;
          vld_q[1] <= 1'b0;
          fresh_q  <= 1'b0;
        end
      end

      if (in_fire && queue_en && !reject_o) begin
        if (!full) begin
          key_q[free_idx] <= in_key_i;
          vld_q[free_idx] <= 1'b1;
        end else begin
          key_q[res_max_q[IW-1:0]] <= in_key_i;
        end
      end

      if (pop_ok) vld_q[res_min_q[IW-1:0]] <= 1'b0;

      if (st_q == ST_PH2) begin
        res_max_q <= ext_max;
        res_min_q <= ext_min;
        res_ok_q  <= 1'b1;
        if (stream_en) begin
          vld_q    <= {{(N-2){1'b0}}, 2'b11};
          key_q[0] <= ext_max[RW-1 -: W];
          key_q[1] <= ext_min[RW-1 -: W];
          fill_q   <= '0;
          if (last_q) begin
            done_q  <= 1'b1;
            fresh_q <= 1'b1;
            last_q  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mmx_extract_chk.sv
module mmx_extract_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   mode_i,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         pop_i,
  input logic [W-1:0] max_o,
  input logic [W-1:0] min_o,
  input logic         out_valid_o,
  input logic         reject_o,
  input logic         pop_err_o
);
  logic [2:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 3'd4)  warm_q <= warm_q + 3'd1;
  end

  AST_INERT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[0] == mode_i[1]) |-> !in_ready_o && !out_valid_o && !reject_o && !pop_err_o); // R1

  AST_STALL_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 3'd4 && mode_i == 2'b01 && $past(mode_i) == 2'b01 && $past(mode_i, 2) == 2'b01
     && $past(mode_i, 3) == 2'b01 && !$past(in_ready_o) && !$past(in_ready_o, 2)) |-> in_ready_o); // R3

  AST_REJECT_IN_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> in_valid_i && in_ready_o && mode_i == 2'b10); // R6

  AST_REJECT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> $stable(max_o) && $stable(min_o)); // R6

  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_err_o |-> pop_i && !out_valid_o); // R7

  AST_ORDERED_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> min_o <= max_o); // R8

  AST_QUEUE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && out_valid_o && !(in_valid_i && in_ready_o) && !pop_i)
      |=> $stable(max_o) && $stable(min_o)); // R9

  AST_BUSY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && in_valid_i && in_ready_o && !reject_o) |=> !out_valid_o && !in_ready_o); // R10
endmodule

bind mmx_extract mmx_extract_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .pop_i(pop_i), .max_o(max_o), .min_o(min_o),
  .out_valid_o(out_valid_o), .reject_o(reject_o), .pop_err_o(pop_err_o));

// File: tb/mmx_extract_tb.sv
module mmx_extract_tb;
  localparam int P = 4;
  localparam int W = 16;
  localparam int N = P * P;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [W-1:0] in_key_i = '0;
  logic         in_last_i = 1'b0;
  logic         pop_i = 1'b0;
  logic [W-1:0] max_o, min_o;
  logic         out_valid_o, reject_o, pop_err_o;

  always #10 clk_i = ~clk_i;

  mmx_extract #(.P(P), .W(W)) u_dut (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct { int mx; int mn; string tag; } exp_t;
  exp_t exp_q[$];
  int   model_q[$];
  logic [W-1:0] seed = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
    return {s[W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // monitor: compare each new result against the scoreboard
  logic prev_v = 1'b0;
  always @(negedge clk_i) begin
    exp_t e;
    if (!rst_ni) prev_v = 1'b0;
    else begin
      if (out_valid_o && !prev_v) begin
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected result", int'(max_o), -1);
        else begin
          e = exp_q.pop_front();
          chk(int'(max_o) == e.mx, e.tag, "max", int'(max_o), e.mx);
          chk(int'(min_o) == e.mn, e.tag, "min", int'(min_o), e.mn);
        end
        chk(min_o <= max_o, "R8", "min<=max", int'(min_o), int'(max_o));
      end
      prev_v = out_valid_o;
    end
  end

  task automatic send(input int key, input bit last, output bit rej, output int stall);
    stall = 0;
    @(negedge clk_i);
    in_valid_i = 1'b1; in_key_i = W'(key); in_last_i = last;
    #1;
    while (!in_ready_o) begin stall++; @(negedge clk_i); #1; end
    rej = reject_o;
    @(posedge clk_i); #1;
    in_valid_i = 1'b0; in_last_i = 1'b0;
  endtask

  task automatic run_stream(input int ks[], input string tag, output int max_stall);
    exp_t e; bit rej; int st;
    e.mx = ks[0]; e.mn = ks[0]; e.tag = tag;
    foreach (ks[i]) begin
      if (ks[i] > e.mx) e.mx = ks[i];
      if (ks[i] < e.mn) e.mn = ks[i];
    end
    exp_q.push_back(e);
    max_stall = 0;
    foreach (ks[i]) begin
      send(ks[i], i == ks.size() - 1, rej, st);
      if (st > max_stall) max_stall = st;
    end
    repeat (4) @(negedge clk_i);
  endtask

  function automatic int qmax();
    int m = model_q[0];
    foreach (model_q[i]) if (model_q[i] > m) m = model_q[i];
    return m;
  endfunction
  function automatic int qmin();
    int m = model_q[0];
    foreach (model_q[i]) if (model_q[i] < m) m = model_q[i];
    return m;
  endfunction

  task automatic q_insert(input int key, input string tag);
    bit rej, exp_rej; int st; exp_t e;
    exp_rej = (model_q.size() == N) && !(key < qmax());
    if (!exp_rej) begin
      if (model_q.size() == N) begin
        foreach (model_q[i]) if (model_q[i] == qmax()) begin model_q[i] = key; break; end
      end else model_q.push_back(key);
      e.mx = qmax(); e.mn = qmin(); e.tag = tag;
      exp_q.push_back(e);
    end
    send(key, 1'b0, rej, st);
    chk(rej == exp_rej, "R6", "reject flag", int'(rej), int'(exp_rej));
    @(negedge clk_i);
    if (!exp_rej) chk(!in_ready_o && !out_valid_o, "R10", "busy after insert", int'(out_valid_o), 0);
  endtask

  task automatic q_pop(input string tag);
    exp_t e; bit err;
    @(negedge clk_i); #1;
    while (!in_ready_o) begin @(negedge clk_i); #1; end
    pop_i = 1'b1; #1;
    err = pop_err_o;
    chk(err == (model_q.size() == 0), "R7", "pop_err", int'(err), int'(model_q.size() == 0));
    if (model_q.size() != 0) begin
      foreach (model_q[i]) if (model_q[i] == qmin()) begin model_q.delete(i); break; end
      if (model_q.size() != 0) begin
        e.mx = qmax(); e.mn = qmin(); e.tag = tag; exp_q.push_back(e);
      end
    end
    @(posedge clk_i); #1;
    pop_i = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk_i);
    mode_i = m;
    repeat (2) @(negedge clk_i);
    if (m == 2'b10) model_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end

  initial begin
    int ks[]; int stall; bit rej; logic [W-1:0] old_max;
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o && !in_ready_o && !reject_o && !pop_err_o, "R1", "reset outputs", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1: inert mode ignores offered records
    in_valid_i = 1'b1; in_key_i = 16'd77;
    repeat (3) begin
      @(negedge clk_i); #1;
      chk(!in_ready_o && !out_valid_o, "R1", "inert mode handshake", int'(in_ready_o), 0);
    end
    in_valid_i = 1'b0;

    // stream mode
    set_mode(2'b01);
    ks = new[40];
    foreach (ks[i]) begin seed = nxt(seed); ks[i] = int'(seed); end
    run_stream(ks, "R2", stall);
    chk(stall == 2, "R3", "pass stall cycles", stall, 2);
    chk(out_valid_o, "R2", "result held", int'(out_valid_o), 1);

    ks = new[N-2];
    foreach (ks[i]) ks[i] = 500 + i;
    run_stream(ks, "R2", stall);

    ks = new[N-1];
    foreach (ks[i]) ks[i] = 1000 + i;
    ks[N-2] = 5;
    run_stream(ks, "R4", stall);

    ks = new[1];
    ks[0] = 4242;
    run_stream(ks, "R4", stall);

    ks = new[3];
    ks[0] = 65535; ks[1] = 0; ks[2] = 300;
    run_stream(ks, "R4", stall);

    // queue mode
    set_mode(2'b10);
    q_pop("R7");
    for (int i = 0; i < N; i++) begin seed = nxt(seed); q_insert(int'(seed) | 16'h0100, "R5"); end
    repeat (3) @(negedge clk_i);
    old_max = max_o;
    q_insert(int'(old_max), "R6");
    q_insert(65535, "R6");
    repeat (3) @(negedge clk_i);
    chk(max_o == old_max, "R9", "outputs after reject", int'(max_o), int'(old_max));
    q_insert(3, "R6");
    q_insert(1, "R6");
    for (int i = 0; i < 5; i++) q_pop("R7");
    repeat (4) @(negedge clk_i);

    // R11: mode change empties the queue
    set_mode(2'b11);
    in_valid_i = 1'b1; in_key_i = 16'd9;
    @(negedge clk_i); #1;
    chk(!in_ready_o && !out_valid_o, "R1", "reserved mode", int'(in_ready_o), 0);
    in_valid_i = 1'b0;
    set_mode(2'b10);
    chk(!out_valid_o, "R11", "valid after mode change", int'(out_valid_o), 0);
    q_pop("R11");
    q_insert(20, "R11");
    q_insert(10, "R11");
    while (model_q.size() != 0) q_pop("R7");
    q_pop("R7");
    repeat (6) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2", "pending results", exp_q.size(), 0);
    finished = 1;
    report();
  end
endmodule